// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives one output clock from one of two input clocks: a fast synthesized clock or the raw reference clock. The chosen source drives a main divider whose ratio is a 5-bit field. Odd ratios keep an even high/low split by also using the falling edge of the source. A binary post-scaler then divides by 1, 2, 4 or 8, so the total ratio is the main value times the scale factor. A main value of 0 or 1 means no division in that stage. When the total ratio is one, the source clock passes straight through a low-phase clock gate.

All configuration pins are static. The block samples them only when an output period ends, so a change never cuts a pulse short. A master enable input is synchronized into the source domain and takes effect only at a period boundary, while the output is low. While the output is stopped, it is either driven low or marked for high impedance through a separate output-enable flag. The choice comes from a configuration bit, and no internal tri-state is needed. The block has no data stream, so every pin is a plain control or clock pin.

Top module: `clkdiv_out`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low, `clk_o` is low and no output period runs. `clk_oe_o` is 1 when `hiz_i` is 0. The output can start only on a source edge after reset has been released.
- R2: For an even total ratio N, `clk_o` has a period of N source periods and is high for exactly N/2 source periods.
- R3: For an odd total ratio N greater than one, `clk_o` has a period of N source periods and is high for exactly N/2 source periods. The half period comes from the falling edge.
- R4: A `div_i` value of 0 or 1 is treated as a main ratio of 1. When the post-scale code is 0, the selected source clock appears unchanged on `clk_o`.
- R5: The post-scale code `scale_i` multiplies the main ratio: code 0 by 1, code 1 by 2, code 2 by 4, code 3 by 8. The total ratio is therefore max(div_i,1) << scale_i.
- R6: `sel_ref_i` = 0 selects the synthesized clock `syn_clk`, and `sel_ref_i` = 1 selects the reference clock `ref_clk` as the divider source.
- R7: While the output is stopped, `clk_o` stays low. `clk_oe_o` is 0 when `hiz_i` = 1, meaning high impedance, and 1 when `hiz_i` = 0, meaning driven low.
- R8: `oe_i` passes through a two-stage synchronizer. Stopping and starting happen only at the end of an output period. The high pulse in progress when `oe_i` falls completes at full width, and no further edge appears until the block is enabled again.
- R9: A change of `div_i`, `scale_i`, `sel_ref_i` or `hiz_i` in the middle of a period leaves that period unchanged. The new setting applies from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| syn_clk | input | 1 | Synthesized high-rate source clock |
| ref_clk | input | 1 | Reference source clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the selected source |
| oe_i | input | 1 | Master output enable, asynchronous |
| div_i | input | 5 | Main divider ratio, 0 and 1 mean undivided |
| scale_i | input | 2 | Post-scale code: 1, 2, 4 or 8 |
| sel_ref_i | input | 1 | 1 selects `ref_clk`, 0 selects `syn_clk` |
| hiz_i | input | 1 | Disabled state: 1 high impedance, 0 driven low |
| clk_o | output | 1 | Divided clock |
| clk_oe_o | output | 1 | Output-enable flag for the pad driver |

## Verification
A configuration written into the middle of a period applies at the next period boundary. The period after it already has the new shape, so the scoreboard queues one item with the old timing, then items with the new timing. A drop of `oe_i` needs two source edges for the synchronizer and then the current period's boundary. The bench therefore waits for the falling edge of `clk_o` and checks that this last pulse is N/2 source periods wide. It checks `clk_oe_o` only a few source periods after the block has stopped. Period and high time are measured between edges of `clk_o` itself, not at fixed times. Any delay the design adds before the first edge therefore cannot move a result.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int P_W   = 5;
  localparam int S_W   = 2;
  localparam int CNT_W = P_W + (1 << S_W) - 1;

  typedef struct packed {
    logic [P_W-1:0] p;
    logic [S_W-1:0] scale;
    logic           use_ref;
    logic           hiz;
  } cfg_t;
endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
  input  logic syn_clk,
  input  logic ref_clk,
  input  logic sel,
  output logic src_clk
);
  always_comb src_clk = sel ? ref_clk : syn_clk;
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
  import clkdiv_pkg::*;
(
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] hi_cnt,
  output logic             odd,
  output logic             bypass
);
  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] total;

  always_comb begin
    eff    = (cfg.p < P_W'(2)) ? CNT_W'(1) : CNT_W'(cfg.p);
    total  = eff << cfg.scale;
    last   = total - CNT_W'(1);
    hi_cnt = (total + CNT_W'(1)) >> 1;
    bypass = (total == CNT_W'(1));
    odd    = total[0] && !bypass;
  end
endmodule

// File: rtl/clkdiv_engine.sv
module clkdiv_engine
  import clkdiv_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_i,
  input  cfg_t             cfg_i,
  output cfg_t             shadow_o,
  output logic             run_o,
  output logic             bnd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o,
  output logic             clk_o,
  output logic             oe_o
);
  logic [SYNC_N-1:0] sync_q;
  cfg_t              shadow_q;
  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last_q;
  logic              hi_q;
  logic              odd_q;
  logic              byp_q;
  logic              hi_neg_q;
  logic              run_neg_q;

  logic              bnd;
  logic              take;
  cfg_t              nxt_cfg;
  logic              nxt_run;
  logic [CNT_W-1:0]  nxt_cnt;
  logic [CNT_W-1:0]  r_last;
  logic [CNT_W-1:0]  r_hi;
  logic              r_odd;
  logic              r_byp;

  always_comb begin
    bnd     = (cnt_q == last_q);
    take    = !rst_n || !run_q || bnd;
    nxt_cfg = take ? cfg_i : shadow_q;
    nxt_run = take ? sync_q[SYNC_N-1] : run_q;
    nxt_cnt = take ? '0 : cnt_q + CNT_W'(1);
  end

  clkdiv_ratio u_ratio (
    .cfg    (nxt_cfg),
    .last   (r_last),
    .hi_cnt (r_hi),
    .odd    (r_odd),
    .bypass (r_byp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      run_q    <= 1'b0;
      cnt_q    <= '0;
      hi_q     <= 1'b0;
      shadow_q <= cfg_i;
      last_q   <= r_last;
      odd_q    <= r_odd;
      byp_q    <= r_byp;
    end else begin
      sync_q   <= {sync_q[SYNC_N-2:0], oe_i};
      run_q    <= nxt_run;
      cnt_q    <= nxt_cnt;
      hi_q     <= nxt_run && (nxt_cnt < r_hi);
      shadow_q <= nxt_cfg;
      last_q   <= r_last;
      odd_q    <= r_odd;
      byp_q    <= r_byp;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      hi_neg_q  <= 1'b0;
      run_neg_q <= 1'b0;
    end else begin
      hi_neg_q  <= hi_q;
      run_neg_q <= run_q;
    end
  end

  always_comb begin
    if (byp_q)      clk_o = clk & run_neg_q;
    else if (odd_q) clk_o = hi_q & hi_neg_q;
    else            clk_o = hi_q;
    oe_o = run_q || run_neg_q || !shadow_q.hiz;
  end

  assign shadow_o = shadow_q;
  assign run_o    = run_q;
  assign bnd_o    = bnd;
  assign cnt_o    = cnt_q;
  assign last_o   = last_q;
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
(
  input  logic           syn_clk,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic           oe_i,
  input  logic [P_W-1:0] div_i,
  input  logic [S_W-1:0] scale_i,
  input  logic           sel_ref_i,
  input  logic           hiz_i,
  output logic           clk_o,
  output logic           clk_oe_o
);
  cfg_t             cfg_in;
  cfg_t             shadow_w;
  logic             src_clk;
  logic             run_w;
  logic             bnd_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] last_w;

  always_comb begin
    cfg_in.p       = div_i;
    cfg_in.scale   = scale_i;
    cfg_in.use_ref = sel_ref_i;
    cfg_in.hiz     = hiz_i;
  end

  clkdiv_src_mux u_mux (
    .syn_clk (syn_clk),
    .ref_clk (ref_clk),
    .sel     (shadow_w.use_ref),
    .src_clk (src_clk)
  );

  clkdiv_engine #(.SYNC_N(2)) u_eng (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .oe_i     (oe_i),
    .cfg_i    (cfg_in),
    .shadow_o (shadow_w),
    .run_o    (run_w),
    .bnd_o    (bnd_w),
    .cnt_o    (cnt_w),
    .last_o   (last_w),
    .clk_o    (clk_o),
    .oe_o     (clk_oe_o)
  );
endmodule

// File: rtl/clkdiv_out_chk.sv
module clkdiv_out_chk
  import clkdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             bnd,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last,
  input logic [P_W-1:0]   cfg_p,
  input logic [S_W-1:0]   cfg_scale,
  input logic             out,
  input logic             out_en
);
  // R1
  start_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> $past(rst_n));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R8
  no_mid_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bnd) |=> run);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bnd) |=> ($stable(cfg_p) && $stable(cfg_scale)));

  // R7
  hiz_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !out);
endmodule

bind clkdiv_out clkdiv_out_chk u_chk (
  .clk       (src_clk),
  .rst_n     (rst_n),
  .run       (run_w),
  .bnd       (bnd_w),
  .cnt       (cnt_w),
  .last      (last_w),
  .cfg_p     (shadow_w.p),
  .cfg_scale (shadow_w.scale),
  .out       (clk_o),
  .out_en    (clk_oe_o)
);

// File: tb/tb_clkdiv_out.sv
`timescale 1ns/1ps
module tb_clkdiv_out;
  localparam real CLK_PERIOD = 10.0;
  localparam real REF_PERIOD = 26.0;

  logic       syn_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       oe_i    = 1'b1;
  logic [4:0] div_i   = 5'd4;
  logic [1:0] scale_i = 2'd0;
  logic       sel_ref_i = 1'b0;
  logic       hiz_i   = 1'b0;
  logic       clk_o;
  logic       clk_oe_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    real   period;
    real   hi;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  bit      arm  = 1'b0;
  bit      have = 1'b0;
  realtime t_rise = 0;
  realtime t_fall = 0;
  int      edge_cnt = 0;

  always #(CLK_PERIOD/2) syn_clk = ~syn_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  clkdiv_out dut (
    .syn_clk   (syn_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .oe_i      (oe_i),
    .div_i     (div_i),
    .scale_i   (scale_i),
    .sel_ref_i (sel_ref_i),
    .hiz_i     (hiz_i),
    .clk_o     (clk_o),
    .clk_oe_o  (clk_oe_o)
  );

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  // monitor: measures each completed period and compares with the queue
  always @(negedge clk_o) t_fall = $realtime;
  always @(posedge clk_o) begin
    edge_cnt = edge_cnt + 1;
    if (arm && have && exp_q.size() > 0) begin
      exp_t e;
      real  per;
      real  hw;
      e   = exp_q.pop_front();
      per = $realtime - t_rise;
      hw  = t_fall - t_rise;
      checks = checks + 1;
      if (!near(per, e.period) || !near(hw, e.hi)) begin
        errors = errors + 1;
        $display("FAIL %s period %0.3f high %0.3f expected period %0.3f high %0.3f",
                 e.tag, per, hw, e.period, e.hi);
      end
    end
    have  = arm;
    t_rise = $realtime;
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic push(input real per, input real hw, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.period = per; e.hi = hw; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 40) begin
      @(posedge clk_o);
      guard++;
    end
    if (exp_q.size() > 0) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL %s output stalled, %0d items pending expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // driver: apply a setting, let it settle, then queue expected periods
  task automatic run_case(input int p, input int s, input bit use_ref, input string tag);
    real t;
    int  n;
    arm = 1'b0;
    div_i = 5'(p); scale_i = 2'(s); sel_ref_i = use_ref;
    repeat (3) @(posedge clk_o);
    #1;
    t = use_ref ? REF_PERIOD : CLK_PERIOD;
    n = ((p < 2) ? 1 : p) << s;
    arm = 1'b1;
    push(n * t, n * t / 2.0, tag, 3);
    drain(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    realtime tr;
    int      ec;
    repeat (4) @(posedge syn_clk);
    #2;
    // R1: reset state
    check_bit("R1 clk_o in reset", clk_o, 1'b0);
    check_bit("R1 clk_oe_o in reset", clk_oe_o, 1'b1);
    ec = edge_cnt;
    repeat (3) @(posedge syn_clk);
    #2;
    check_bit("R1 no edge in reset", edge_cnt != ec, 1'b0);
    rst_n = 1'b1;

    run_case(4, 0, 1'b0, "R2 even div 4");
    run_case(6, 0, 1'b0, "R2 even div 6");
    run_case(5, 0, 1'b0, "R3 odd div 5");
    run_case(3, 0, 1'b0, "R3 odd div 3");
    run_case(1, 0, 1'b0, "R4 div 1 passthrough");
    run_case(0, 0, 1'b0, "R4 div 0 passthrough");
    run_case(3, 3, 1'b0, "R5 div 3 scale 8");
    run_case(5, 1, 1'b0, "R5 div 5 scale 2");
    run_case(0, 2, 1'b0, "R5 div 0 scale 4");
    run_case(31, 1, 1'b0, "R5 div 31 scale 2");
    run_case(3, 0, 1'b1, "R6 ref div 3");
    run_case(2, 1, 1'b1, "R6 ref div 2 scale 2");
    run_case(4, 0, 1'b0, "R6 back to syn div 4");

    // R9: mid-period change keeps current period
    @(posedge clk_o);
    #1;
    div_i = 5'd6;
    push(40.0, 20.0, "R9 old period kept", 1);
    push(60.0, 30.0, "R9 new period", 2);
    arm = 1'b1;
    drain("R9");
    arm = 1'b0;

    run_case(4, 0, 1'b0, "R8 settle div 4");

    // R8: disable mid high pulse, pulse completes, then silence
    @(posedge clk_o);
    tr = $realtime;
    #1;
    oe_i = 1'b0;
    @(negedge clk_o);
    checks = checks + 1;
    if (!near($realtime - tr, 20.0)) begin
      errors = errors + 1;
      $display("FAIL R8 last pulse width %0.3f expected 20.000", $realtime - tr);
    end
    #(CLK_PERIOD * 4);
    ec = edge_cnt;
    #(CLK_PERIOD * 30);
    check_bit("R8 no edge while disabled", edge_cnt != ec, 1'b0);
    // R7: disabled level driven low
    check_bit("R7 clk_o low disabled", clk_o, 1'b0);
    check_bit("R7 driven low oe", clk_oe_o, 1'b1);
    hiz_i = 1'b1;
    #(CLK_PERIOD * 4);
    check_bit("R7 hiz oe", clk_oe_o, 1'b0);
    check_bit("R7 clk_o low hiz", clk_o, 1'b0);
    hiz_i = 1'b0;
    #(CLK_PERIOD * 4);
    check_bit("R7 back to driven", clk_oe_o, 1'b1);

    // R8: restart gives whole periods
    oe_i = 1'b1;
    run_case(4, 0, 1'b0, "R8 restart div 4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule